// File: doc/BRIEF.md
# Interval Timer Host Bus Interface

This block is the processor-facing side of a three-channel interval timer. An 8-bit host bus with an active-low select, active-low read and write strobes and a two-bit address reaches three count channels and one configuration register. The configuration register can only be written. Each byte written there names its target channel in the top two bits. The block holds the per-channel access pattern, mode and number format and pulses a configure strobe to that channel. Writes to a channel address are assembled into a 16-bit load value according to that channel's access pattern.

On the read side the block returns the live count bytes, a frozen copy taken by a latch command, or a status byte taken by a multi-channel read-back command. The counting logic is not part of this block. Each channel appears as a 16-bit count input, an output-level input and a null-count input, plus configure and load strobes going out to it. All strobes are sampled on the block clock: a write acts once, on the first clock edge at which it is seen active, and a read sequence advances once the read strobe ends.

Top module: `timer_host_if`

## Requirements
- R1: While `cs_n` is high, no write has any effect: no configure or load strobe follows, and the channel state is unchanged.
- R2: A write to address 3 with bits [7:6] = 0..2 and bits [5:4] != 0 is a control word for channel [7:6]. It stores access [5:4], mode [3:1] and BCD [0], and one cycle later pulses `cfg_we[ch]` for exactly one cycle, with `cfg_mode` and `cfg_bcd` driven.
- R3: Writes to address 0..2 load that channel by its access pattern. Pattern 01 loads {8'h00, byte} and pattern 10 loads {byte, 8'h00}, each after one write. Pattern 11 loads {second, first} on the second write. A one-cycle `load_we[ch]` pulse comes with `load_val`.
- R4: A read at address 3 returns no register contents: `dout_en` stays low and `dout` is 8'h00.
- R5: `dout_en` is high exactly while `cs_n` and `rd_n` are low and the address is 0..2.
- R6: With nothing latched, a channel read returns live count bytes. Pattern 01 returns the low byte, pattern 10 the high byte, and pattern 11 the low byte and then the high byte on successive reads.
- R7: A control word with access bits [5:4] = 00 is a counter-latch command. It freezes the channel's count until the latched bytes have been read by the channel's pattern. A further latch command while one is pending is ignored.
- R8: A control word with [7:6] = 11 is read-back. Bits [3:1] select channels 2, 1 and 0 (bit 1 is channel 0). Bit 5 low latches the count and bit 4 low latches the status, on every selected channel in one write. Latches already pending are not overwritten.
- R9: A latched status byte is {out, null-count, access[1:0], mode[2:0], BCD}. It is returned on the first read of that channel, ahead of any latched count bytes.
- R10: Write and read byte sequences on the same channel are tracked apart. Interleaving a read between the two bytes of a pattern-11 load changes neither the loaded value nor the read byte order.
- R11: After reset, no strobe is active and every channel has nothing latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0..2 channel, 3 configuration register |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_en | output | 1 | Read data drive enable |
| cnt_i | input | 48 | Live count of channels 0..2 (channel n in bits 16n+15:16n) |
| out_i | input | 3 | Output level of each channel |
| null_i | input | 3 | Null-count flag of each channel |
| cfg_we | output | 3 | One-cycle configure strobe per channel |
| cfg_mode | output | 3 | Mode for the strobed channel |
| cfg_bcd | output | 1 | BCD flag for the strobed channel |
| load_we | output | 3 | One-cycle count load strobe per channel |
| load_val | output | 16 | Assembled load value |

## Verification
Directed sequences cover each command type on its own. A control word is followed by its load bytes, and the live count is read in each access pattern. A latch is taken and the count input is then changed, with a second latch issued to show it is discarded. A read-back of two channels shows status-before-count ordering and keeps channels apart. One case puts a read between the two load bytes, which separates the read and write byte pointers. A seeded random loop then programs random channels with random patterns, modes and data. Each load value is compared against a bench function, so a wrong byte placement or a wrong channel routing shows up.

// File: rtl/timer_host_if.sv
module timer_host_if #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  input  logic [6*DW-1:0]   cnt_i,
  input  logic [2:0]        out_i,
  input  logic [2:0]        null_i,
  output logic [2:0]        cfg_we,
  output logic [2:0]        cfg_mode,
  output logic              cfg_bcd,
  output logic [2:0]        load_we,
  output logic [2*DW-1:0]   load_val
);
  localparam int CW = 2 * DW;
  localparam int NCH = 3;

  logic [1:0]    acc   [NCH];
  logic [2:0]    mode  [NCH];
  logic          bcd   [NCH];
  logic          wr_tg [NCH];
  logic          rd_tg [NCH];
  logic [DW-1:0] lo_hold [NCH];
  logic          cl_v  [NCH];
  logic [CW-1:0] cl_r  [NCH];
  logic          st_v  [NCH];
  logic [DW-1:0] st_r  [NCH];

  logic wr_act_q, rd_act_q;
  logic [1:0] rd_ch_q;

  wire wr_act  = !cs_n && !wr_n;
  wire rd_act  = !cs_n && !rd_n && (addr != 2'b11);
  wire wr_fall = wr_act && !wr_act_q;
  wire rd_done = rd_act_q && !(rd_act && addr == rd_ch_q);

  wire [1:0] ch = (addr == 2'b11) ? 2'd0 : addr;
  wire [1:0] cw_ch = din[7:6];

  logic [CW-1:0] src;
  logic          hi_sel;
  always_comb begin
    src    = cl_v[ch] ? cl_r[ch] : cnt_i[ch*CW +: CW];
    hi_sel = (acc[ch] == 2'b10) || (acc[ch] == 2'b11 && rd_tg[ch]);
  end

  assign dout_en = rd_act;
  assign dout = !rd_act ? '0 : st_v[ch] ? st_r[ch] : (hi_sel ? src[CW-1:DW] : src[DW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      rd_ch_q  <= '0;
      cfg_we   <= '0;
      cfg_mode <= '0;
      cfg_bcd  <= 1'b0;
      load_we  <= '0;
      load_val <= '0;
      for (int i = 0; i < NCH; i++) begin
        acc[i] <= '0; mode[i] <= '0; bcd[i] <= 1'b0;
        wr_tg[i] <= 1'b0; rd_tg[i] <= 1'b0; lo_hold[i] <= '0;
        cl_v[i] <= 1'b0; cl_r[i] <= '0; st_v[i] <= 1'b0; st_r[i] <= '0;
      end
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      rd_ch_q  <= ch;
      cfg_we   <= '0;
      load_we  <= '0;

      if (rd_done) begin
        if (st_v[rd_ch_q]) st_v[rd_ch_q] <= 1'b0;
        else if (acc[rd_ch_q] == 2'b11 && !rd_tg[rd_ch_q]) rd_tg[rd_ch_q] <= 1'b1;
        else begin
          rd_tg[rd_ch_q] <= 1'b0;
          cl_v[rd_ch_q]  <= 1'b0;
        end
      end

      if (wr_fall) begin
        if (addr == 2'b11) begin
          if (cw_ch == 2'b11) begin
            for (int i = 0; i < NCH; i++) begin
              if (din[i+1]) begin
                if (!din[4] && !st_v[i]) begin
                  st_v[i] <= 1'b1;
                  st_r[i] <= {out_i[i], null_i[i], acc[i], mode[i], bcd[i]};
                end
                if (!din[5] && !cl_v[i]) begin
                  cl_v[i] <= 1'b1;
                  cl_r[i] <= cnt_i[i*CW +: CW];
                end
              end
            end
          end else if (din[5:4] == 2'b00) begin
            if (!cl_v[cw_ch]) begin
              cl_v[cw_ch] <= 1'b1;
              cl_r[cw_ch] <= cnt_i[cw_ch*CW +: CW];
            end
          end else begin
            acc[cw_ch]   <= din[5:4];
            mode[cw_ch]  <= din[3:1];
            bcd[cw_ch]   <= din[0];
            wr_tg[cw_ch] <= 1'b0;
            rd_tg[cw_ch] <= 1'b0;
            cl_v[cw_ch]  <= 1'b0;
            st_v[cw_ch]  <= 1'b0;
            cfg_we[cw_ch] <= 1'b1;
            cfg_mode <= din[3:1];
            cfg_bcd  <= din[0];
          end
        end else begin
          case (acc[ch])
            2'b01: begin load_we[ch] <= 1'b1; load_val <= {{DW{1'b0}}, din}; end
            2'b10: begin load_we[ch] <= 1'b1; load_val <= {din, {DW{1'b0}}}; end
            2'b11: begin
              if (!wr_tg[ch]) begin
                lo_hold[ch] <= din;
                wr_tg[ch]   <= 1'b1;
              end else begin
                wr_tg[ch]   <= 1'b0;
                load_we[ch] <= 1'b1;
                load_val    <= {din, lo_hold[ch]};
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/timer_host_if_chk.sv
module timer_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic [2:0] cfg_we,
  input logic [2:0] load_we
);
  assert_cs_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cfg_we == 3'b000 && load_we == 3'b000));

  assert_one_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_we) && !((|cfg_we) && (|load_we)));

  assert_load_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_we) |-> $past(!cs_n && !wr_n && addr != 2'b11));

  assert_ctl_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'b11) |-> (!dout_en && dout == 8'h00));

  assert_oe_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !rd_n));

  assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_we));
endmodule

bind timer_host_if timer_host_if_chk chk (.*);

// File: tb/tb_timer_host_if.sv
module tb_timer_host_if;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic dout_en;
  logic [47:0] cnt_i = 0;
  logic [2:0] out_i = 0, null_i = 0;
  logic [2:0] cfg_we, cfg_mode, load_we;
  logic cfg_bcd;
  logic [15:0] load_val;

  int checks = 0, fails = 0;
  logic [2:0] c_cfg, c_mode, c_load;
  logic c_bcd;
  logic [15:0] c_val;
  logic [7:0] r_d;
  logic r_en;

  timer_host_if dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic sel_n = 0);
    @(negedge clk); cs_n = sel_n; wr_n = 0; addr = a; din = d;
    @(posedge clk); #1;
    c_cfg = cfg_we; c_mode = cfg_mode; c_bcd = cfg_bcd; c_load = load_we; c_val = load_val;
    @(negedge clk); wr_n = 1; cs_n = 1;
  endtask

  task automatic rd(logic [1:0] a);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1; r_d = dout; r_en = dout_en;
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  function automatic logic [7:0] cw(logic [1:0] c, logic [1:0] a, logic [2:0] m, logic b);
    return {c, a, m, b};
  endfunction

  function automatic logic [15:0] exp_load(logic [1:0] a, logic [7:0] b0, logic [7:0] b1);
    case (a)
      2'b01: return {8'h00, b0};
      2'b10: return {b0, 8'h00};
      default: return {b1, b0};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 strobes", {cfg_we, load_we, 1'b0, dout_en}, 0);
    @(negedge clk); rst_n = 1;

    rd(2'b11);
    chk("R4 en", r_en, 0);
    chk("R4 data", r_d, 0);

    wr(2'b11, cw(2'd1, 2'b11, 3'd3, 1'b1), 1'b1);
    chk("R1 cs high", {c_cfg, c_load}, 0);
    wr(2'b11, cw(2'd1, 2'b11, 3'd3, 1'b1));
    chk("R2 cfg_we", c_cfg, 3'b010);
    chk("R2 mode/bcd", {c_mode, c_bcd}, {3'd3, 1'b1});
    wr(2'b01, 8'h34);
    chk("R3 first byte no load", c_load, 0);
    wr(2'b01, 8'h12);
    chk("R3 load ch1", {c_load, c_val}, {3'b010, 16'h1234});
    wr(2'b01, 8'h99, 1'b1);
    chk("R1 data write ignored", c_load, 0);
    wr(2'b01, 8'h56);
    wr(2'b01, 8'h78);
    chk("R1 pointer unchanged", c_val, 16'h7856);

    cnt_i[31:16] = 16'hA55A;
    rd(2'b01);
    chk("R5 en", r_en, 1);
    chk("R6 lsb", r_d, 8'h5A);
    rd(2'b01);
    chk("R6 msb", r_d, 8'hA5);
    @(negedge clk); cs_n = 1; rd_n = 0; addr = 1; #1;
    chk("R5 cs high", dout_en, 0);
    @(negedge clk); rd_n = 1;

    wr(2'b11, cw(2'd1, 2'b00, 3'd0, 1'b0));
    cnt_i[31:16] = 16'h1111;
    wr(2'b11, cw(2'd1, 2'b00, 3'd0, 1'b0));
    rd(2'b01);
    chk("R7 latched lsb", r_d, 8'h5A);
    cnt_i[31:16] = 16'h2222;
    rd(2'b01);
    chk("R7 latched msb", r_d, 8'hA5);
    rd(2'b01);
    chk("R7 live after", r_d, 8'h22);
    rd(2'b01);

    wr(2'b11, cw(2'd0, 2'b01, 3'd2, 1'b0));
    wr(2'b11, cw(2'd2, 2'b10, 3'd5, 1'b1));
    cnt_i[15:0] = 16'hBEEF; cnt_i[47:32] = 16'hCAFE;
    out_i = 3'b100; null_i = 3'b001;
    wr(2'b11, 8'b1100_1010);
    cnt_i[15:0] = 16'h0000; cnt_i[47:32] = 16'h0000;
    rd(2'b00);
    chk("R9 status ch0", r_d, {1'b0, 1'b1, 2'b01, 3'd2, 1'b0});
    rd(2'b00);
    chk("R8 count ch0", r_d, 8'hEF);
    rd(2'b10);
    chk("R9 status ch2", r_d, {1'b1, 1'b0, 2'b10, 3'd5, 1'b1});
    rd(2'b10);
    chk("R8 count ch2", r_d, 8'hCA);
    rd(2'b00);
    chk("R8 live ch0", r_d, 8'h00);
    cnt_i[47:32] = 16'h4321;
    wr(2'b11, 8'b1110_1000);
    cnt_i[47:32] = 16'h0000;
    rd(2'b10);
    chk("R8 status-only ch2", r_d, {1'b1, 1'b0, 2'b10, 3'd5, 1'b1});
    rd(2'b10);
    chk("R8 no count latched", r_d, 8'h00);

    cnt_i[31:16] = 16'hF00D;
    wr(2'b01, 8'hC3);
    rd(2'b01);
    chk("R10 read lsb", r_d, 8'h0D);
    wr(2'b01, 8'h3C);
    chk("R10 load", {c_load, c_val}, {3'b010, 16'h3CC3});
    rd(2'b01);
    chk("R10 read msb", r_d, 8'hF0);

    for (int k = 0; k < 150; k++) begin
      logic [1:0] c, a;
      logic [2:0] m;
      logic [7:0] b0, b1;
      c = 2'($urandom_range(0, 2));
      a = 2'($urandom_range(1, 3));
      m = 3'($urandom_range(0, 5));
      b0 = 8'($urandom); b1 = 8'($urandom);
      wr(2'b11, cw(c, a, m, k[0]));
      chk("R2 random cfg", {c_cfg, c_mode, c_bcd}, {3'(1 << c), m, k[0]});
      wr(c, b0);
      if (a == 2'b11) begin
        chk("R3 random hold", c_load, 0);
        wr(c, b1);
      end
      chk("R3 random load", {c_load, c_val}, {3'(1 << c), exp_load(a, b0, b1)});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule